// File: doc/BRIEF.md
# In-Order DRAM Command Sequencer

This block sits between a transaction source and a DRAM command bus. It accepts memory transactions (a read/write flag, an auto-precharge flag, a bank, a row and a column) into an eight-entry queue. It turns the transaction at the head of the queue into the DRAM commands that transaction needs and issues those commands one at a time. Depending on the state of the target bank, the commands are a precharge, an activate and a column command. Reads and writes leave strictly in arrival order, whatever bank they target. No later transaction is looked at until the head's column command has been taken.

A refresh timer raises a one-cycle request. The request is held inside the block until it is serviced. At the next command boundary it wins over the head transaction and is issued as a precharge-all followed by an auto-refresh. A command already on the bus is always allowed to complete first, and a transaction whose sequence is half-issued is never abandoned. After the refresh, the head transaction continues as if its bank were closed.

An external tracker reports which bank has a row open, and which row, on the per-bank status inputs. The block reads that status once, when a transaction reaches the head, and then steps through the rest of the sequence itself. Timing legality, the data path and the refresh timer live elsewhere.

Top module: `inorder_cmd_sched`

## Requirements
- R1: The queue holds 8 transactions. `txn_ready` is low exactly while 8 are held, and a transaction is taken on a cycle with `txn_valid` and `txn_ready` both high.
- R2: If the head transaction's bank is open on the same row, only its column command is issued.
- R3: If the head transaction's bank is closed, an activate (op 1) carrying its bank and row is issued, followed by its column command.
- R4: If the head transaction's bank is open on another row, the block issues a precharge (op 0) to that bank, then the activate, then the column command.
- R5: The column command's op is 2 for a read, 3 for a write, 4 for a read with auto-precharge and 5 for a write with auto-precharge. It carries the transaction's bank and column.
- R6: Column commands leave in the order the transactions were accepted, across all banks.
- R7: A presented command holds its op, bank, row and column until `cmd_ready` is high. After each accepted command, `cmd_valid` is low for the next cycle.
- R8: A pending refresh is issued at the next command boundary, ahead of the head transaction, as precharge-all (op 6) followed directly by auto-refresh (op 7).
- R9: A refresh that arrives in the middle of a transaction's sequence does not drop that transaction. Afterwards the transaction resumes with an activate and then its column command.
- R10: A refresh request that arrives while a command is stalled is held. It is issued after the stalled command is accepted.
- R11: After reset, `cmd_valid` is low and `txn_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | Transaction offered |
| txn_ready | output | 1 | Queue can take a transaction |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_autopre | input | 1 | Close the row after the column access |
| txn_bank | input | BANK_W | Target bank |
| txn_row | input | ROW_W | Target row |
| txn_col | input | COL_W | Target column |
| refresh_req | input | 1 | One-cycle refresh request |
| bank_open | input | 2**BANK_W | Per-bank row-open flags |
| bank_open_row | input | 2**BANK_W*ROW_W | Open row of each bank, bank 0 in the low bits |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Command taken |
| cmd_op | output | 3 | Command code (see R3 to R8) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | Command column |

## Verification
A wrong sequencing phase shows at the ports no later than the next presented command: the op is wrong, for example a column command with no activate after a refresh, or a repeated precharge. A refresh that is lost or issued twice shows within two command slots as a missing or extra op 6 / op 7 pair. A queue pointer or count error shows as columns or banks out of arrival order, or as `txn_ready` at the wrong level once eight transactions are held behind a stalled command.

// File: rtl/sched_pkg.sv
package sched_pkg;
  parameter int BANK_W = 2;
  parameter int ROW_W  = 14;
  parameter int COL_W  = 10;

  typedef enum logic [2:0] {
    OP_PRE  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_RDA  = 3'd4,
    OP_WRA  = 3'd5,
    OP_PREA = 3'd6,
    OP_REF  = 3'd7
  } cmd_op_e;

  // Next step of the head transaction; PH_NEW means "consult bank status".
  typedef enum logic [1:0] {
    PH_NEW = 2'd0,
    PH_PRE = 2'd1,
    PH_ACT = 2'd2,
    PH_COL = 2'd3
  } txn_ph_e;

  typedef struct packed {
    logic              wr;
    logic              ap;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } txn_t;

  localparam int TXN_W = $bits(txn_t);
endpackage

// File: rtl/sched_rst_sync.sv
module sched_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/sched_txn_fifo.sv
module sched_txn_fifo #(
  parameter  int WIDTH = 8,
  parameter  int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_d = push ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_data;
  end

  assign head_data = mem[rd_ptr_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign count     = cnt_q;
endmodule

// File: rtl/sched_step_sel.sv
module sched_step_sel
  import sched_pkg::*;
#(
  parameter  int BW = 2,
  parameter  int RW = 14,
  localparam int NB = 1 << BW
) (
  input  logic [BW-1:0]    bank,
  input  logic [RW-1:0]    row,
  input  logic [NB-1:0]    open_vec,
  input  logic [NB*RW-1:0] row_vec,
  output txn_ph_e          first_step
);
  logic [RW-1:0] rows [NB];

  for (genvar g = 0; g < NB; g++) begin : g_rows
    assign rows[g] = row_vec[g*RW +: RW];
  end

  always_comb begin
    if (!open_vec[bank])        first_step = PH_ACT;
    else if (rows[bank] == row) first_step = PH_COL;
    else                        first_step = PH_PRE;
  end
endmodule

// File: rtl/inorder_cmd_sched.sv
module inorder_cmd_sched
  import sched_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int NB    = 1 << BANK_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txn_valid,
  output logic                txn_ready,
  input  logic                txn_write,
  input  logic                txn_autopre,
  input  logic [BANK_W-1:0]   txn_bank,
  input  logic [ROW_W-1:0]    txn_row,
  input  logic [COL_W-1:0]    txn_col,
  input  logic                refresh_req,
  input  logic [NB-1:0]       bank_open,
  input  logic [NB*ROW_W-1:0] bank_open_row,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [2:0]          cmd_op,
  output logic [BANK_W-1:0]   cmd_bank,
  output logic [ROW_W-1:0]    cmd_row,
  output logic [COL_W-1:0]    cmd_col
);
  logic rst_n_s;
  sched_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  // transaction queue
  txn_t             in_txn, head;
  logic [TXN_W-1:0] head_bits;
  logic             q_empty, q_full, push, pop;
  logic [CNT_W-1:0] q_cnt;

  assign in_txn = '{wr: txn_write, ap: txn_autopre, bank: txn_bank,
                    row: txn_row, col: txn_col};
  assign push      = txn_valid && txn_ready;
  assign txn_ready = !q_full;
  assign head      = txn_t'(head_bits);

  sched_txn_fifo #(.WIDTH(TXN_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n_s), .push(push), .push_data(in_txn),
    .pop(pop), .head_data(head_bits), .empty(q_empty), .full(q_full),
    .count(q_cnt)
  );

  // first step of the head, from bank status
  txn_ph_e sel_step;
  sched_step_sel #(.BW(BANK_W), .RW(ROW_W)) u_sel (
    .bank(head.bank), .row(head.row), .open_vec(bank_open),
    .row_vec(bank_open_row), .first_step(sel_step)
  );

  // state
  logic        cv_q, cv_d;
  txn_ph_e     ph_q, ph_d, step;
  logic        ref_pend_q, ref_pend_d;
  logic        ref_ph_q, ref_ph_d;
  cmd_op_e     op_q, op_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic        load, acc, acc_col;

  function automatic cmd_op_e col_op(input logic wr, input logic ap);
    if (ap) return wr ? OP_WRA : OP_RDA;
    else    return wr ? OP_WR  : OP_RD;
  endfunction

  assign step    = (ph_q == PH_NEW) ? sel_step : ph_q;
  assign acc     = cv_q && cmd_ready;
  assign acc_col = acc && (op_q == OP_RD || op_q == OP_WR ||
                           op_q == OP_RDA || op_q == OP_WRA);
  assign pop     = acc_col;

  // command choice at a boundary (no command on the bus)
  always_comb begin
    load   = 1'b0;
    op_d   = op_q;
    bank_d = bank_q;
    row_d  = row_q;
    col_d  = col_q;
    if (!cv_q) begin
      if (ref_ph_q) begin
        load = 1'b1; op_d = OP_REF;
        bank_d = '0; row_d = '0; col_d = '0;
      end else if (ref_pend_q) begin
        load = 1'b1; op_d = OP_PREA;
        bank_d = '0; row_d = '0; col_d = '0;
      end else if (!q_empty) begin
        load   = 1'b1;
        bank_d = head.bank;
        row_d  = head.row;
        col_d  = head.col;
        case (step)
          PH_PRE:  op_d = OP_PRE;
          PH_ACT:  op_d = OP_ACT;
          default: op_d = col_op(head.wr, head.ap);
        endcase
      end
    end
  end

  // sequencing state
  always_comb begin
    cv_d       = cv_q;
    ph_d       = ph_q;
    ref_ph_d   = ref_ph_q;
    ref_pend_d = ref_pend_q || refresh_req;
    if (load)     cv_d = 1'b1;
    else if (acc) cv_d = 1'b0;
    if (acc) begin
      case (op_q)
        OP_PRE:  ph_d = PH_ACT;
        OP_ACT:  ph_d = PH_COL;
        OP_PREA: ref_ph_d = 1'b1;
        OP_REF: begin
          ref_ph_d   = 1'b0;
          ref_pend_d = refresh_req;
          ph_d       = PH_ACT;
        end
        default: ph_d = PH_NEW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cv_q       <= 1'b0;
      ph_q       <= PH_NEW;
      ref_pend_q <= 1'b0;
      ref_ph_q   <= 1'b0;
    end else begin
      cv_q       <= cv_d;
      ph_q       <= ph_d;
      ref_pend_q <= ref_pend_d;
      ref_ph_q   <= ref_ph_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      op_q   <= op_d;
      bank_q <= bank_d;
      row_q  <= row_d;
      col_q  <= col_d;
    end
  end

  assign cmd_valid = cv_q;
  assign cmd_op    = op_q;
  assign cmd_bank  = bank_q;
  assign cmd_row   = row_q;
  assign cmd_col   = col_q;
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int BW    = 2,
  parameter int RW    = 14,
  parameter int CW    = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txn_ready,
  input logic             refresh_req,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic [BW-1:0]    cmd_bank,
  input logic [RW-1:0]    cmd_row,
  input logic [CW-1:0]    cmd_col,
  input logic [CNT_W-1:0] q_count,
  input logic             ref_pend
);
  // R1
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CNT_W'(DEPTH)) |-> !txn_ready);

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
      $stable(cmd_bank) && $stable(cmd_row) && $stable(cmd_col)));

  // R7
  gap_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  // R8
  prea_then_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd6) |=> ##1 (cmd_valid && cmd_op == 3'd7));

  // R3
  act_then_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd1 && !ref_pend && !refresh_req)
      |=> ##1 (cmd_valid && cmd_op >= 3'd2 && cmd_op <= 3'd5));

  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> ref_pend);
endmodule

bind inorder_cmd_sched sched_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W),
  .BW(sched_pkg::BANK_W), .RW(sched_pkg::ROW_W), .CW(sched_pkg::COL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_ready(txn_ready), .refresh_req(refresh_req),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
  .q_count(q_cnt), .ref_pend(ref_pend_q)
);

// File: tb/inorder_cmd_sched_bench.sv
module inorder_cmd_sched_bench;
  import sched_pkg::*;
  localparam int NB = 1 << BANK_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, txn_valid, txn_ready, txn_write, txn_autopre, refresh_req;
  logic [BANK_W-1:0] txn_bank;
  logic [ROW_W-1:0]  txn_row;
  logic [COL_W-1:0]  txn_col;
  logic [NB-1:0]     bank_open;
  logic [NB*ROW_W-1:0] bank_open_row;
  logic cmd_valid, cmd_ready;
  logic [2:0] cmd_op;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0]  cmd_row;
  logic [COL_W-1:0]  cmd_col;

  inorder_cmd_sched u_inorder_cmd_sched (.*);

  // bank status tracker of the surrounding system
  logic [ROW_W-1:0] trk_row [NB];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_open <= '0;
    else if (cmd_valid && cmd_ready) begin
      case (cmd_op)
        3'd0: bank_open[cmd_bank] <= 1'b0;
        3'd1: begin bank_open[cmd_bank] <= 1'b1; trk_row[cmd_bank] <= cmd_row; end
        3'd4, 3'd5: bank_open[cmd_bank] <= 1'b0;
        3'd6: bank_open <= '0;
        default: ;
      endcase
    end
  end
  for (genvar g = 0; g < NB; g++) begin : g_rowv
    assign bank_open_row[g*ROW_W +: ROW_W] = trk_row[g];
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk_eq(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic get_cmd(output int op, output int bk, output int rw, output int cl,
                         input bit with_ref, input string tag);
    int waited = 0;
    while (!cmd_valid && waited < 50) begin @(negedge clk); waited++; end
    if (!cmd_valid) begin
      chk_eq(tag, "command presented", 0, 1);
      op = -1; bk = -1; rw = -1; cl = -1;
      return;
    end
    op = int'(cmd_op); bk = int'(cmd_bank); rw = int'(cmd_row); cl = int'(cmd_col);
    cmd_ready = 1'b1; refresh_req = with_ref;
    @(negedge clk);
    cmd_ready = 1'b0; refresh_req = 1'b0;
    chk_eq("R7", "idle cycle after accept", int'(cmd_valid), 0);
  endtask

  task automatic push(input logic wr, input logic ap, input int bk, input int rw, input int cl);
    txn_valid = 1'b1; txn_write = wr; txn_autopre = ap;
    txn_bank = BANK_W'(bk); txn_row = ROW_W'(rw); txn_col = COL_W'(cl);
    while (!txn_ready) @(negedge clk);
    @(negedge clk);
    txn_valid = 1'b0;
  endtask

  function automatic int col_code(input logic wr, input logic ap);
    return ap ? (wr ? 5 : 4) : (wr ? 3 : 2);
  endfunction

  function automatic int calc_n(input int bk, input int rw);
    if (!bank_open[bk]) return 2;
    return (int'(trk_row[bk]) == rw) ? 1 : 3;
  endfunction

  task automatic expect_txn(input logic wr, input logic ap, input int bk, input int rw,
                            input int cl, input int n, input string tag);
    int op, b, r, c;
    if (n == 3) begin
      get_cmd(op, b, r, c, 1'b0, tag);
      chk_eq(tag, "precharge op", op, 0);
      chk_eq(tag, "precharge bank", b, bk);
    end
    if (n >= 2) begin
      get_cmd(op, b, r, c, 1'b0, tag);
      chk_eq(tag, "activate op", op, 1);
      chk_eq(tag, "activate bank", b, bk);
      chk_eq(tag, "activate row", r, rw);
    end
    get_cmd(op, b, r, c, 1'b0, tag);
    chk_eq("R5", "column op", op, col_code(wr, ap));
    chk_eq(tag, "column bank", b, bk);
    chk_eq(tag, "column col", c, cl);
  endtask

  task automatic expect_refresh(input string tag);
    int op, b, r, c;
    get_cmd(op, b, r, c, 1'b0, tag);
    chk_eq(tag, "precharge-all op", op, 6);
    get_cmd(op, b, r, c, 1'b0, tag);
    chk_eq(tag, "auto-refresh op", op, 7);
  endtask

  typedef struct packed {
    logic wr; logic ap; logic [1:0] bank; logic [13:0] row; logic [9:0] col; logic [1:0] n;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 2'd0, 14'd5, 10'd16, 2'd2},
    '{1'b1, 1'b0, 2'd0, 14'd5, 10'd17, 2'd1},
    '{1'b0, 1'b1, 2'd1, 14'd7, 10'd18, 2'd2},
    '{1'b1, 1'b0, 2'd0, 14'd9, 10'd19, 2'd3},
    '{1'b1, 1'b1, 2'd1, 14'd7, 10'd20, 2'd2},
    '{1'b0, 1'b1, 2'd0, 14'd9, 10'd21, 2'd1},
    '{1'b0, 1'b0, 2'd2, 14'd3, 10'd22, 2'd2},
    '{1'b0, 1'b0, 2'd2, 14'd4, 10'd23, 2'd3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int op, b, r, c;
    rst_n = 1'b0; txn_valid = 1'b0; txn_write = 1'b0; txn_autopre = 1'b0;
    txn_bank = '0; txn_row = '0; txn_col = '0; refresh_req = 1'b0; cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11
    chk_eq("R11", "cmd_valid after reset", int'(cmd_valid), 0);
    chk_eq("R11", "txn_ready after reset", int'(txn_ready), 1);

    // table walk: R2 hit, R3 closed, R4 conflict
    for (int i = 0; i < 8; i++) begin
      string tg;
      tg = (VEC[i].n == 2'd1) ? "R2" : (VEC[i].n == 2'd2) ? "R3" : "R4";
      push(VEC[i].wr, VEC[i].ap, int'(VEC[i].bank), int'(VEC[i].row), int'(VEC[i].col));
      expect_txn(VEC[i].wr, VEC[i].ap, int'(VEC[i].bank), int'(VEC[i].row),
                 int'(VEC[i].col), int'(VEC[i].n), tg);
    end

    // R8 refresh while idle
    refresh_req = 1'b1; @(negedge clk); refresh_req = 1'b0;
    expect_refresh("R8");

    // R8 refresh beats a transaction arriving in the same cycle
    txn_valid = 1'b1; txn_write = 1'b0; txn_autopre = 1'b0;
    txn_bank = 2'd1; txn_row = 14'd8; txn_col = 10'd3; refresh_req = 1'b1;
    @(negedge clk);
    txn_valid = 1'b0; refresh_req = 1'b0;
    expect_refresh("R8");
    expect_txn(1'b0, 1'b0, 1, 8, 3, 2, "R8");

    // R9 refresh lands between precharge and activate
    push(1'b1, 1'b0, 0, 1, 4);
    expect_txn(1'b1, 1'b0, 0, 1, 4, 2, "R9");
    push(1'b0, 1'b0, 0, 2, 7);
    get_cmd(op, b, r, c, 1'b1, "R9");
    chk_eq("R9", "precharge op", op, 0);
    expect_refresh("R9");
    expect_txn(1'b0, 1'b0, 0, 2, 7, 2, "R9");

    // R10 refresh while a command is stalled
    push(1'b1, 1'b1, 3, 6, 9);
    while (!cmd_valid) @(negedge clk);
    refresh_req = 1'b1; @(negedge clk); refresh_req = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R7", "stalled command still valid", int'(cmd_valid), 1);
    chk_eq("R10", "stalled command still activate", int'(cmd_op), 1);
    get_cmd(op, b, r, c, 1'b0, "R10");
    chk_eq("R10", "stalled activate accepted", op, 1);
    expect_refresh("R10");
    expect_txn(1'b1, 1'b1, 3, 6, 9, 2, "R10");

    // R1 / R6 fill the queue behind a stalled head, then drain in order
    for (int i = 0; i < 8; i++)
      push(i[0], 1'b0, i % 4, (i == 5) ? 31 : 30 + i, 100 + i);
    @(negedge clk);
    chk_eq("R1", "txn_ready with 8 held", int'(txn_ready), 0);
    for (int i = 0; i < 8; i++) begin
      int rw;
      rw = (i == 5) ? 31 : 30 + i;
      expect_txn(i[0], 1'b0, i % 4, rw, 100 + i, calc_n(i % 4, rw), "R6");
    end
    @(negedge clk);
    chk_eq("R1", "txn_ready after drain", int'(txn_ready), 1);
    chk_eq("R6", "no extra command after drain", int'(cmd_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule